// File: doc/BRIEF.md
# SPI FIFO Status and Request Logic

This block sits between a synchronous serial port's shift engine and the rest of the chip. It holds two character FIFOs. The transmit FIFO is filled by the processor and drained by the serial side. The receive FIFO is filled by the serial side and drained by the processor. From the fill levels of the two FIFOs the block derives request and interrupt lines, so that a processor or a DMA controller can move the data.

A DMA controller reading received characters can move one character per request, because the receive request is raised as soon as a single character is waiting. A DMA controller feeding the transmitter is asked for data only while the transmit FIFO is at most half full. That guarantees room for a four-character burst. Receive overruns are latched and reported until software clears them. A single group line merges every enabled interrupt source.

Top module: `spi_fifo_status`

## Requirements
- R1: `rx_dma_req` and `rx_not_empty` are both 1 exactly when the receive FIFO held at least one character in the previous cycle.
- R2: `tx_req` is 1 exactly when mask bit 1 was set and the transmit FIFO held at most DEPTH-BURST characters (4 of 8 by default) in the previous cycle.
- R3: `tx_empty` is 1 exactly when the transmit FIFO held zero characters in the previous cycle.
- R4: Characters leave the receive FIFO in arrival order. `cpu_rd_data` shows the oldest character combinationally and is popped by `cpu_rd_en`. A read while the FIFO is empty shows 0 and leaves the FIFO unchanged.
- R5: Characters leave the transmit FIFO on `ser_tx_data` in write order, popped by `ser_tx_pop`. A write while the FIFO holds DEPTH (8) characters is ignored.
- R6: A receive push while the receive FIFO holds DEPTH characters drops the character and sets a sticky overrun flag. `ovr_irq` reflects that flag AND mask bit 2.
- R7: `clr_wr` with `clr_wdata` bit 2 set clears the overrun flag, while a clear write with bit 2 at 0 has no effect. A new overrun in the same cycle as a clear wins.
- R8: `grp_irq` is the OR of the enabled sources. Mask bit 0 enables receive-not-empty, bit 1 enables transmit-half-or-less, and bit 2 enables overrun. `mask_wr` loads the mask from `mask_wdata`.
- R9: A push and a pop in the same cycle leave a FIFO's level unchanged when it is neither empty nor full.
- R10: After reset both FIFOs are empty, the mask is 0 and the overrun flag is clear. All outputs are 0 except `tx_empty`, which is 1.
- R11: All request, interrupt and status outputs are registered. They keep their old values for one clock edge after the edge that changed a FIFO level, the mask or the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | Processor write into the transmit FIFO |
| cpu_wr_data | input | DATA_W | Character to transmit |
| cpu_rd_en | input | 1 | Processor pop from the receive FIFO |
| cpu_rd_data | output | DATA_W | Oldest received character, 0 when empty |
| ser_rx_push | input | 1 | Serial side pushes a received character |
| ser_rx_data | input | DATA_W | Received character |
| ser_tx_pop | input | 1 | Serial side takes the next character to send |
| ser_tx_data | output | DATA_W | Oldest transmit character, 0 when empty |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_wdata | input | 3 | New mask value |
| clr_wr | input | 1 | Write to the clear register |
| clr_wdata | input | 3 | Clear bits; bit 2 clears overrun |
| rx_dma_req | output | 1 | Receive request, one character available |
| tx_req | output | 1 | Transmit request, room for a burst |
| ovr_irq | output | 1 | Masked overrun interrupt |
| grp_irq | output | 1 | OR of all enabled sources |
| rx_not_empty | output | 1 | Raw receive-not-empty status |
| tx_empty | output | 1 | Raw transmit-empty status |

## Verification
Each of the eight mask values is combined with a full fill-and-drain sweep of both FIFOs, one past full and one past empty. Comparing the mask values separates the masked outputs from the raw ones, and the sweep finds the exact level where the transmit request threshold switches. Concurrent push-and-pop patterns are applied at empty, mid and full levels to tell a level-preserving update apart from a rejected push. Overrun-then-clear sequences, including a clear with the wrong bit and a clear colliding with a new overrun, distinguish sticky, clearable and set-priority behaviour. Every step also confirms that the outputs held their old values for one edge.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   localparam int IRQ_W   = 3;
   localparam int IRQ_RX  = 0;
   localparam int IRQ_TX  = 1;
   localparam int IRQ_OVR = 2;
   typedef logic [IRQ_W-1:0] irq_vec_t;
endpackage

// File: rtl/sfs_char_fifo.sv
module sfs_char_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty,
   output logic              push_drop
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              push_ok, pop_ok;

   assign full      = (count == CNT_MAX);
   assign empty     = (count == '0);
   assign push_ok   = push & ~full;
   assign pop_ok    = pop & ~empty;
   assign push_drop = push & full;
   assign head      = empty ? '0 : mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/sfs_level_flags.sv
module sfs_level_flags #(
   parameter int DEPTH = 8,
   parameter int BURST = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_cnt,
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic             tx_en,
   output logic             rx_ne_raw,
   output logic             tx_room_raw,
   output logic             rx_dma_req,
   output logic             rx_not_empty,
   output logic             tx_req,
   output logic             tx_empty
);
   localparam logic [CNT_W-1:0] TX_TH = CNT_W'(DEPTH - BURST);

   assign rx_ne_raw   = (rx_cnt != '0);
   assign tx_room_raw = (tx_cnt <= TX_TH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_dma_req   <= 1'b0;
         rx_not_empty <= 1'b0;
         tx_req       <= 1'b0;
         tx_empty     <= 1'b1;
      end else begin
         rx_dma_req   <= rx_ne_raw;
         rx_not_empty <= rx_ne_raw;
         tx_req       <= tx_room_raw & tx_en;
         tx_empty     <= (tx_cnt == '0);
      end
   end
endmodule

// File: rtl/sfs_irq_ctrl.sv
module sfs_irq_ctrl
   import sfs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mask_wr,
   input  irq_vec_t mask_wdata,
   input  logic     clr_wr,
   input  irq_vec_t clr_wdata,
   input  logic     ovr_event,
   input  logic     rx_ne_raw,
   input  logic     tx_room_raw,
   output irq_vec_t mask_q,
   output logic     ovr_irq,
   output logic     grp_irq
);
   logic     ovr_q;
   irq_vec_t src, enabled;

   always_comb begin
      src          = '0;
      src[IRQ_RX]  = rx_ne_raw;
      src[IRQ_TX]  = tx_room_raw;
      src[IRQ_OVR] = ovr_q;
      enabled      = src & mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         ovr_q   <= 1'b0;
         ovr_irq <= 1'b0;
         grp_irq <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= mask_wdata;
         if (ovr_event)
            ovr_q <= 1'b1;
         else if (clr_wr && clr_wdata[IRQ_OVR])
            ovr_q <= 1'b0;
         ovr_irq <= enabled[IRQ_OVR];
         grp_irq <= |enabled;
      end
   end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
   import sfs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int BURST  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic              cpu_rd_en,
   output logic [DATA_W-1:0] cpu_rd_data,
   input  logic              ser_rx_push,
   input  logic [DATA_W-1:0] ser_rx_data,
   input  logic              ser_tx_pop,
   output logic [DATA_W-1:0] ser_tx_data,
   input  logic              mask_wr,
   input  logic [2:0]        mask_wdata,
   input  logic              clr_wr,
   input  logic [2:0]        clr_wdata,
   output logic              rx_dma_req,
   output logic              tx_req,
   output logic              ovr_irq,
   output logic              grp_irq,
   output logic              rx_not_empty,
   output logic              tx_empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (BURST < 1 || 2 * BURST > DEPTH) begin : g_bad_burst
         $error("BURST must be between 1 and DEPTH/2");
      end
   endgenerate

   logic [CNT_W-1:0] rx_cnt, tx_cnt;
   logic             rx_full, rx_empty, tx_full, tx_fifo_empty;
   logic             rx_drop, tx_drop;
   logic             rx_ne_raw, tx_room_raw;
   irq_vec_t         mask_q;

   sfs_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (cpu_wr_en),
      .push_data (cpu_wr_data),
      .pop       (ser_tx_pop),
      .head      (ser_tx_data),
      .count     (tx_cnt),
      .full      (tx_full),
      .empty     (tx_fifo_empty),
      .push_drop (tx_drop)
   );

   sfs_char_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ser_rx_push),
      .push_data (ser_rx_data),
      .pop       (cpu_rd_en),
      .head      (cpu_rd_data),
      .count     (rx_cnt),
      .full      (rx_full),
      .empty     (rx_empty),
      .push_drop (rx_drop)
   );

   sfs_level_flags #(.DEPTH(DEPTH), .BURST(BURST)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_cnt       (rx_cnt),
      .tx_cnt       (tx_cnt),
      .tx_en        (mask_q[IRQ_TX]),
      .rx_ne_raw    (rx_ne_raw),
      .tx_room_raw  (tx_room_raw),
      .rx_dma_req   (rx_dma_req),
      .rx_not_empty (rx_not_empty),
      .tx_req       (tx_req),
      .tx_empty     (tx_empty)
   );

   sfs_irq_ctrl u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mask_wr     (mask_wr),
      .mask_wdata  (mask_wdata),
      .clr_wr      (clr_wr),
      .clr_wdata   (clr_wdata),
      .ovr_event   (rx_drop),
      .rx_ne_raw   (rx_ne_raw),
      .tx_room_raw (tx_room_raw),
      .mask_q      (mask_q),
      .ovr_irq     (ovr_irq),
      .grp_irq     (grp_irq)
   );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] rx_cnt,
   input logic [CNT_W-1:0] tx_cnt,
   input logic [2:0]       mask_q,
   input logic             mask_wr,
   input logic             cpu_wr_en,
   input logic             cpu_rd_en,
   input logic             ser_rx_push,
   input logic             ser_tx_pop,
   input logic             rx_dma_req,
   input logic             tx_req,
   input logic             ovr_irq,
   input logic             grp_irq,
   input logic             tx_empty
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   AST_RX_REQ_ON: assert property (@(posedge clk) disable iff (!rst_n) (rx_cnt != '0) |=> rx_dma_req); // R1
   AST_RX_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n) (rx_cnt == '0) |=> !rx_dma_req); // R1
   AST_TX_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !mask_q[1] |=> !tx_req); // R2
   AST_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (tx_cnt == '0) |=> tx_empty); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rx_cnt <= FULL) && (tx_cnt <= FULL)); // R5
   AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (tx_cnt == FULL && cpu_wr_en && !ser_tx_pop) |=> (tx_cnt == FULL)); // R5
   AST_OVR_RAISED: assert property (@(posedge clk) disable iff (!rst_n) (rx_cnt == FULL && ser_rx_push && mask_q[2] && !mask_wr) |=> ##1 ovr_irq); // R6
   AST_GRP_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == 3'b000) |=> !grp_irq); // R8
   AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (ser_rx_push && cpu_rd_en && rx_cnt != '0 && rx_cnt != FULL) |=> $stable(rx_cnt)); // R9
endmodule

bind spi_fifo_status sfs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sfs_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_cnt       (rx_cnt),
   .tx_cnt       (tx_cnt),
   .mask_q       (mask_q),
   .mask_wr      (mask_wr),
   .cpu_wr_en    (cpu_wr_en),
   .cpu_rd_en    (cpu_rd_en),
   .ser_rx_push  (ser_rx_push),
   .ser_tx_pop   (ser_tx_pop),
   .rx_dma_req   (rx_dma_req),
   .tx_req       (tx_req),
   .ovr_irq      (ovr_irq),
   .grp_irq      (grp_irq),
   .tx_empty     (tx_empty)
);

// File: tb/spi_fifo_status_tb_top.sv
module spi_fifo_status_tb_top;
   localparam int DEPTH = 8;
   localparam int TH    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_wr_en = 1'b0, cpu_rd_en = 1'b0, ser_rx_push = 1'b0, ser_tx_pop = 1'b0;
   logic       mask_wr = 1'b0, clr_wr = 1'b0;
   logic [7:0] cpu_wr_data = '0, ser_rx_data = '0;
   logic [2:0] mask_wdata = '0, clr_wdata = '0;
   logic [7:0] cpu_rd_data, ser_tx_data;
   logic       rx_dma_req, tx_req, ovr_irq, grp_irq, rx_not_empty, tx_empty;

   int compared = 0, mismatched = 0;
   bit done = 1'b0;

   logic [7:0] rxq[$];
   logic [7:0] txq[$];
   logic [2:0] m_mask = '0;
   bit         m_ovr = 1'b0;

   always #5 clk = ~clk;

   spi_fifo_status dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
      .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
      .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
      .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .clr_wr(clr_wr), .clr_wdata(clr_wdata),
      .rx_dma_req(rx_dma_req), .tx_req(tx_req), .ovr_irq(ovr_irq),
      .grp_irq(grp_irq), .rx_not_empty(rx_not_empty), .tx_empty(tx_empty)
   );

   task automatic chk(input string tag, input string ctx, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, ctx, act, exp);
      end
   endtask

   function automatic logic [5:0] model_vec();
      bit rne, room;
      rne  = rxq.size() > 0;
      room = txq.size() <= TH;
      return {rne, rne, m_mask[1] & room, txq.size() == 0,
              m_mask[2] & m_ovr,
              (m_mask[0] & rne) | (m_mask[1] & room) | (m_mask[2] & m_ovr)};
   endfunction

   function automatic logic [5:0] dut_vec();
      return {rx_dma_req, rx_not_empty, tx_req, tx_empty, ovr_irq, grp_irq};
   endfunction

   task automatic check_outputs(input string ctx);
      logic [5:0] e, a;
      e = model_vec();
      a = dut_vec();
      chk("R1", {ctx, " rx_dma_req"}, a[5], e[5]);
      chk("R1", {ctx, " rx_not_empty"}, a[4], e[4]);
      chk("R2", {ctx, " tx_req"}, a[3], e[3]);
      chk("R3", {ctx, " tx_empty"}, a[2], e[2]);
      chk("R6", {ctx, " ovr_irq"}, a[1], e[1]);
      chk("R8", {ctx, " grp_irq"}, a[0], e[0]);
   endtask

   // one operation: drive at a falling edge, hold one edge, then settle one more
   task automatic op(input bit wr, input logic [7:0] wd, input bit rd,
                     input bit rp, input logic [7:0] rdt, input bit tp,
                     input bit mw, input logic [2:0] md,
                     input bit cw, input logic [2:0] cd, input string ctx);
      logic [5:0] old;
      bit rx_full, tx_full, rx_can_pop, tx_can_pop, set_ovr;
      cpu_wr_en = wr; cpu_wr_data = wd; cpu_rd_en = rd;
      ser_rx_push = rp; ser_rx_data = rdt; ser_tx_pop = tp;
      mask_wr = mw; mask_wdata = md; clr_wr = cw; clr_wdata = cd;
      #1;
      if (rd) chk("R4", {ctx, " cpu_rd_data"}, cpu_rd_data, rxq.size() > 0 ? rxq[0] : 8'h00);
      if (tp) chk("R5", {ctx, " ser_tx_data"}, ser_tx_data, txq.size() > 0 ? txq[0] : 8'h00);
      old = model_vec();
      @(negedge clk);
      cpu_wr_en = 0; cpu_rd_en = 0; ser_rx_push = 0; ser_tx_pop = 0; mask_wr = 0; clr_wr = 0;
      chk("R11", {ctx, " held outputs"}, dut_vec(), old);
      rx_full = rxq.size() == DEPTH;
      tx_full = txq.size() == DEPTH;
      rx_can_pop = rxq.size() > 0;
      tx_can_pop = txq.size() > 0;
      set_ovr = rp && rx_full;
      if (rd && rx_can_pop) void'(rxq.pop_front());
      if (rp && !rx_full) rxq.push_back(rdt);
      if (tp && tx_can_pop) void'(txq.pop_front());
      if (wr && !tx_full) txq.push_back(wd);
      if (mw) m_mask = md;
      if (set_ovr) m_ovr = 1'b1;
      else if (cw && cd[2]) m_ovr = 1'b0;
      @(negedge clk);
      check_outputs(ctx);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10", "reset outputs", dut_vec(), 6'b000100);
      check_outputs("R10 reset");

      for (int m = 0; m < 8; m++) begin
         op(0, 0, 0, 0, 0, 0, 1, 3'(m), 0, 0, "R8 mask load");
         for (int i = 0; i < DEPTH + 1; i++)
            op(1, 8'(m * 16 + i), 0, 0, 0, 0, 0, 0, 0, 0, "R5 tx fill");
         for (int i = 0; i < DEPTH + 1; i++)
            op(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 tx drain");
         for (int i = 0; i < DEPTH + 1; i++)
            op(0, 0, 0, 1, 8'(8'hA0 + m * 16 + i), 0, 0, 0, 0, 0, "R6 rx fill");
         for (int i = 0; i < DEPTH + 1; i++)
            op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4 rx drain");
         op(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b011, "R7 wrong clear bit");
         op(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b100, "R7 clear");
      end

      op(0, 0, 0, 0, 0, 0, 1, 3'b111, 0, 0, "R8 all enabled");
      // R9: concurrent push and pop at empty, mid and full levels
      op(0, 0, 1, 1, 8'h11, 0, 0, 0, 0, 0, "R9 rx empty push+pop");
      op(0, 0, 0, 1, 8'h12, 0, 0, 0, 0, 0, "R9 rx add");
      op(0, 0, 0, 1, 8'h13, 0, 0, 0, 0, 0, "R9 rx add");
      for (int i = 0; i < 4; i++)
         op(0, 0, 1, 1, 8'h20 + 8'(i), 0, 0, 0, 0, 0, "R9 rx mid push+pop");
      for (int i = 0; i < 4; i++)
         op(1, 8'h30 + 8'(i), 0, 0, 0, 1, 0, 0, 0, 0, "R9 tx push+pop");
      for (int i = 0; i < DEPTH; i++)
         op(1, 8'h40 + 8'(i), 0, 0, 0, 0, 0, 0, 0, 0, "R2 tx refill");
      op(1, 8'h55, 0, 0, 0, 1, 0, 0, 0, 0, "R9 tx full push+pop");
      while (rxq.size() < DEPTH)
         op(0, 0, 0, 1, 8'h60 + 8'(rxq.size()), 0, 0, 0, 0, 0, "R6 rx top up");
      op(0, 0, 1, 1, 8'h77, 0, 0, 0, 0, 0, "R6 rx full push+pop");
      op(0, 0, 0, 1, 8'h78, 0, 0, 0, 0, 0, "R6 rx overrun");
      op(0, 0, 0, 1, 8'h79, 0, 0, 0, 1, 3'b100, "R7 set beats clear");
      op(0, 0, 0, 0, 0, 0, 1, 3'b011, 0, 0, "R8 overrun masked");
      op(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b100, "R7 clear again");
      while (rxq.size() > 0) op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4 final drain");
      while (txq.size() > 0) op(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 final drain");
      op(0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R4 empty reads");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule